// File: doc/BRIEF.md
# Open-Page SDRAM Command Sequencer

This block turns host read and write requests, each naming a bank, a row and a column, into the command stream for a four-bank double-data-rate SDRAM. It takes one request at a time over a valid/ready handshake. Each request becomes the shortest legal series of commands. A closed bank gets an activate and then the column command. A bank whose open row matches the request gets the column command alone. A bank with a different row open gets a precharge, an activate and then the column command.

The page stays open after an access unless the request asks for auto-precharge. In that case the column command carries the auto-precharge flag and the bank is treated as closed from then on. The block holds the open row and a set of spacing counters for each bank, plus shared counters for the data bus. It issues a command only once every minimum spacing that applies to it has elapsed, and at most one command per cycle. The command pins, bank address and address are all driven from registers.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the command pins show NOP (CS#,RAS#,CAS#,WE# = 0,1,1,1), `req_ready` is high and every bank is closed, so the first access to any bank begins with ACTIVE.
- R2: An access to a closed bank issues ACTIVE, with the row on `cmd_addr` and the bank on `cmd_ba`. The READ or WRITE follows no sooner than tRCD = 3 cycles after the ACTIVE.
- R3: An access to the row already open in its bank issues only the column command, with no PRECHARGE or ACTIVE before it.
- R4: An access to another row of an open bank issues PRECHARGE with `cmd_addr` all zero (bit 10 low, so only `cmd_ba` is closed). The PRECHARGE comes no sooner than tRAS = 6 cycles after that bank's ACTIVE, and the next ACTIVE comes no sooner than tRP = 3 cycles after it.
- R5: Commands are encoded on CS#,RAS#,CAS#,WE# as ACTIVE 0011, READ 0101, WRITE 0100 and PRECHARGE 0010.
- R6: On READ and WRITE, `cmd_addr[9:0]` holds the column, `cmd_addr[10]` holds the auto-precharge request and `cmd_addr[12:11]` are zero.
- R7: Back-to-back READs are 2 cycles apart (a burst of 4 fills 2 cycles), so the data bus has no idle cycle. Back-to-back WRITEs are also 2 cycles apart.
- R8: A READ comes no sooner than 4 cycles after a WRITE. This is 1 cycle to first write data, 2 data cycles and a 1-cycle turnaround. A PRECHARGE to the written bank comes no sooner than 5 cycles after the WRITE (the same 3 cycles plus 2 of write recovery).
- R9: A WRITE comes no sooner than 5 cycles after a READ. This is the CAS latency of 2.5 rounded up to 3, plus the 2 burst cycles. A PRECHARGE comes no sooner than 2 cycles after a READ to that bank.
- R10: An auto-precharge access leaves its bank closed. The next access to that bank issues ACTIVE without PRECHARGE, no sooner than tRP after the earliest moment an explicit PRECHARGE would have been legal.
- R11: `req_ready` drops in the cycle after a request is accepted and rises again only in the cycle its READ or WRITE appears on the command pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the page after this access |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Starting column |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address of the command |
| cmd_addr | output | 13 | Row, column or flag address of the command |

## Verification
A request seen with `req_ready` high is taken at that edge. Its first command appears two cycles later, and each later command of the same request appears one cycle after its predecessor, unless a spacing rule delays it. A new request follows its predecessor's column command without a gap, so a column-to-first-command distance of two cycles is the floor.

The bench logs every non-NOP command at the falling edge, together with a cycle count. It then replays the request list through an arithmetic model of earliest legal times. In that model each command falls on the latest of its pipeline floor, its bank limits and the shared bus limits. The model's commands, fields and cycle numbers are compared one for one with the log.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Command encodings on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } sdram_cmd_e;

    // Default geometry and timing (cycles)
    localparam int DEF_BAW    = 2;
    localparam int DEF_ROWW   = 13;
    localparam int DEF_COLW   = 10;
    localparam int DEF_AW     = 13;
    localparam int DEF_APBIT  = 10;
    localparam int DEF_TRCD   = 3;
    localparam int DEF_TRP    = 3;
    localparam int DEF_TRAS   = 6;
    localparam int DEF_CLX2   = 5;   // CAS latency times two
    localparam int DEF_BL     = 4;
    localparam int DEF_TDQSS  = 1;
    localparam int DEF_TWTR   = 1;
    localparam int DEF_TWRP   = 2;

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
    parameter int ROWW   = 13,
    parameter int CW     = 5,
    parameter int TRCD   = 3,
    parameter int TRAS   = 6,
    parameter int TRP    = 3,
    parameter int RD2PRE = 2,
    parameter int WR2PRE = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act_i,
    input  logic            pre_i,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic            ap_i,
    input  logic [ROWW-1:0] row_i,
    output logic            open_o,
    output logic [ROWW-1:0] row_o,
    output logic            act_ok_o,
    output logic            pre_ok_o,
    output logic            col_ok_o
);

    localparam logic [CW-1:0] L_RCD = CW'(TRCD - 1);
    localparam logic [CW-1:0] L_RAS = CW'(TRAS - 1);
    localparam logic [CW-1:0] L_RP  = CW'(TRP - 1);
    localparam logic [CW-1:0] L_RDP = CW'(RD2PRE - 1);
    localparam logic [CW-1:0] L_WRP = CW'(WR2PRE - 1);

    typedef struct packed {
        logic            open;
        logic [ROWW-1:0] row;
        logic [CW-1:0]   act_w;
        logic [CW-1:0]   pre_w;
        logic [CW-1:0]   col_w;
    } bank_t;

    bank_t bk_d, bk_q;

    function automatic logic [CW-1:0] tick(input logic [CW-1:0] v);
        return (v == '0) ? v : v - CW'(1);
    endfunction

    function automatic logic [CW-1:0] later(input logic [CW-1:0] a, input logic [CW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    always_comb begin
        bk_d       = bk_q;
        bk_d.act_w = tick(bk_q.act_w);
        bk_d.pre_w = tick(bk_q.pre_w);
        bk_d.col_w = tick(bk_q.col_w);
        if (act_i) begin
            bk_d.open  = 1'b1;
            bk_d.row   = row_i;
            bk_d.col_w = L_RCD;
            bk_d.pre_w = later(bk_d.pre_w, L_RAS);
        end
        if (pre_i) begin
            bk_d.open  = 1'b0;
            bk_d.act_w = later(bk_d.act_w, L_RP);
        end
        if (rd_i || wr_i) begin
            bk_d.pre_w = later(bk_d.pre_w, rd_i ? L_RDP : L_WRP);
            if (ap_i) begin
                // internal precharge at the earliest legal point, then tRP
                bk_d.open  = 1'b0;
                bk_d.act_w = bk_d.pre_w + CW'(TRP);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign open_o   = bk_q.open;
    assign row_o    = bk_q.row;
    assign act_ok_o = (bk_q.act_w == '0);
    assign pre_ok_o = (bk_q.pre_w == '0);
    assign col_ok_o = (bk_q.col_w == '0);

    // Elapsed-cycle counters used only by the checks below
    localparam int SW = 5;
    logic [SW-1:0] since_act, since_pre, since_rd, since_wr;

    function automatic logic [SW-1:0] up(input logic [SW-1:0] v);
        return (v == '1) ? v : v + SW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_act <= '1;
            since_pre <= '1;
            since_rd  <= '1;
            since_wr  <= '1;
        end else begin
            since_act <= act_i ? '0 : up(since_act);
            since_pre <= pre_i ? '0 : up(since_pre);
            since_rd  <= rd_i  ? '0 : up(since_rd);
            since_wr  <= wr_i  ? '0 : up(since_wr);
        end
    end

    assert_act_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> !bk_q.open);
    assert_trcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i || wr_i) |-> (since_act >= SW'(TRCD - 1)));
    assert_col_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i || wr_i) |-> bk_q.open);
    assert_tras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> (since_act >= SW'(TRAS - 1)));
    assert_trp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> (since_pre >= SW'(TRP - 1)));
    assert_wr_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> (since_wr >= SW'(WR2PRE - 1)));
    assert_rd_pre_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> (since_rd >= SW'(RD2PRE - 1)));
    assert_ap_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_i || wr_i) && ap_i) |=> !open_o);

endmodule

// File: rtl/sdram_bus_timer.sv
module sdram_bus_timer #(
    parameter int CW    = 5,
    parameter int RD2RD = 2,
    parameter int RD2WR = 5,
    parameter int WR2WR = 2,
    parameter int WR2RD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic wr_i,
    output logic rd_ok_o,
    output logic wr_ok_o
);

    localparam logic [CW-1:0] L_RR = CW'(RD2RD - 1);
    localparam logic [CW-1:0] L_RW = CW'(RD2WR - 1);
    localparam logic [CW-1:0] L_WW = CW'(WR2WR - 1);
    localparam logic [CW-1:0] L_WR = CW'(WR2RD - 1);

    typedef struct packed {
        logic [CW-1:0] rd_w;
        logic [CW-1:0] wr_w;
    } bus_t;

    bus_t bs_d, bs_q;

    function automatic logic [CW-1:0] tick(input logic [CW-1:0] v);
        return (v == '0) ? v : v - CW'(1);
    endfunction

    function automatic logic [CW-1:0] later(input logic [CW-1:0] a, input logic [CW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    always_comb begin
        bs_d.rd_w = tick(bs_q.rd_w);
        bs_d.wr_w = tick(bs_q.wr_w);
        if (rd_i) begin
            bs_d.rd_w = later(bs_d.rd_w, L_RR);
            bs_d.wr_w = later(bs_d.wr_w, L_RW);
        end
        if (wr_i) begin
            bs_d.wr_w = later(bs_d.wr_w, L_WW);
            bs_d.rd_w = later(bs_d.rd_w, L_WR);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign rd_ok_o = (bs_q.rd_w == '0);
    assign wr_ok_o = (bs_q.wr_w == '0);

    localparam int SW = 5;
    logic [SW-1:0] since_rd, since_wr;

    function automatic logic [SW-1:0] up(input logic [SW-1:0] v);
        return (v == '1) ? v : v + SW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rd <= '1;
            since_wr <= '1;
        end else begin
            since_rd <= rd_i ? '0 : up(since_rd);
            since_wr <= wr_i ? '0 : up(since_wr);
        end
    end

    assert_one_col_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_i && wr_i));
    assert_rd_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> (since_rd >= SW'(RD2RD - 1)));
    assert_wr_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (since_wr >= SW'(WR2WR - 1)));
    assert_wr_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> (since_wr >= SW'(WR2RD - 1)));
    assert_rd_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (since_rd >= SW'(RD2WR - 1)));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int BAW   = DEF_BAW,
    parameter int ROWW  = DEF_ROWW,
    parameter int COLW  = DEF_COLW,
    parameter int AW    = DEF_AW,
    parameter int APBIT = DEF_APBIT,
    parameter int TRCD  = DEF_TRCD,
    parameter int TRP   = DEF_TRP,
    parameter int TRAS  = DEF_TRAS,
    parameter int CLX2  = DEF_CLX2,
    parameter int BL    = DEF_BL,
    parameter int TDQSS = DEF_TDQSS,
    parameter int TWTR  = DEF_TWTR,
    parameter int TWRP  = DEF_TWRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic            req_autopre,
    input  logic [BAW-1:0]  req_bank,
    input  logic [ROWW-1:0] req_row,
    input  logic [COLW-1:0] req_col,
    output logic            cmd_cs_n,
    output logic            cmd_ras_n,
    output logic            cmd_cas_n,
    output logic            cmd_we_n,
    output logic [BAW-1:0]  cmd_ba,
    output logic [AW-1:0]   cmd_addr
);

    localparam int NBANK  = 2 ** BAW;
    localparam int CLCYC  = (CLX2 + 1) / 2;
    localparam int BURST  = BL / 2;
    localparam int RD2RD  = BURST;
    localparam int RD2WR  = CLCYC + BURST;
    localparam int RD2PRE = BURST;
    localparam int WR2WR  = BURST;
    localparam int WR2RD  = TDQSS + BURST + TWTR;
    localparam int WR2PRE = TDQSS + BURST + TWRP;
    localparam int CW     = $clog2(TRAS + WR2PRE + TRP + RD2WR + 1);

    typedef struct packed {
        logic            busy;
        logic [BAW-1:0]  bank;
        logic [ROWW-1:0] row;
        logic [COLW-1:0] col;
        logic            wr;
        logic            ap;
        logic [3:0]      cmd;
        logic [BAW-1:0]  ba;
        logic [AW-1:0]   addr;
    } seq_t;

    seq_t sq_d, sq_q;
    logic do_act, do_pre, do_rd, do_wr;

    logic [NBANK-1:0] b_open, b_act_ok, b_pre_ok, b_col_ok;
    logic [ROWW-1:0]  b_row [NBANK];
    logic             bus_rd_ok, bus_wr_ok;

    logic            sel_open, sel_act_ok, sel_pre_ok, sel_col_ok, sel_hit;
    logic [ROWW-1:0] sel_row;

    assign sel_open   = b_open[sq_q.bank];
    assign sel_act_ok = b_act_ok[sq_q.bank];
    assign sel_pre_ok = b_pre_ok[sq_q.bank];
    assign sel_col_ok = b_col_ok[sq_q.bank];
    assign sel_row    = b_row[sq_q.bank];
    assign sel_hit    = sel_open && (sel_row == sq_q.row);

    always_comb begin
        sq_d   = sq_q;
        sq_d.cmd = CMD_NOP;
        do_act = 1'b0;
        do_pre = 1'b0;
        do_rd  = 1'b0;
        do_wr  = 1'b0;
        if (!sq_q.busy) begin
            if (req_valid) begin
                sq_d.busy = 1'b1;
                sq_d.bank = req_bank;
                sq_d.row  = req_row;
                sq_d.col  = req_col;
                sq_d.wr   = req_write;
                sq_d.ap   = req_autopre;
            end
        end else if (sel_hit) begin
            if (sel_col_ok && (sq_q.wr ? bus_wr_ok : bus_rd_ok)) begin
                do_rd    = !sq_q.wr;
                do_wr    = sq_q.wr;
                sq_d.cmd = sq_q.wr ? CMD_WR : CMD_RD;
                sq_d.ba  = sq_q.bank;
                sq_d.addr = '0;
                sq_d.addr[COLW-1:0] = sq_q.col;
                sq_d.addr[APBIT]    = sq_q.ap;
                sq_d.busy = 1'b0;
            end
        end else if (sel_open) begin
            if (sel_pre_ok) begin
                do_pre    = 1'b1;
                sq_d.cmd  = CMD_PRE;
                sq_d.ba   = sq_q.bank;
                sq_d.addr = '0;
            end
        end else begin
            if (sel_act_ok) begin
                do_act    = 1'b1;
                sq_d.cmd  = CMD_ACT;
                sq_d.ba   = sq_q.bank;
                sq_d.addr = AW'(sq_q.row);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q     <= '0;
            sq_q.cmd <= CMD_NOP;
        end else begin
            sq_q <= sq_d;
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic mine;
        assign mine = (sq_q.bank == BAW'(g));
        sdram_bank_track #(
            .ROWW(ROWW), .CW(CW), .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP),
            .RD2PRE(RD2PRE), .WR2PRE(WR2PRE)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_i   (do_act && mine),
            .pre_i   (do_pre && mine),
            .rd_i    (do_rd && mine),
            .wr_i    (do_wr && mine),
            .ap_i    (sq_q.ap),
            .row_i   (sq_q.row),
            .open_o  (b_open[g]),
            .row_o   (b_row[g]),
            .act_ok_o(b_act_ok[g]),
            .pre_ok_o(b_pre_ok[g]),
            .col_ok_o(b_col_ok[g])
        );
    end

    sdram_bus_timer #(
        .CW(CW), .RD2RD(RD2RD), .RD2WR(RD2WR), .WR2WR(WR2WR), .WR2RD(WR2RD)
    ) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (do_rd),
        .wr_i   (do_wr),
        .rd_ok_o(bus_rd_ok),
        .wr_ok_o(bus_wr_ok)
    );

    assign req_ready = !sq_q.busy;
    assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = sq_q.cmd;
    assign cmd_ba   = sq_q.ba;
    assign cmd_addr = sq_q.addr;

    assert_take_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_ready_after_col_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> (sq_q.cmd == CMD_RD || sq_q.cmd == CMD_WR));
    assert_pre_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.cmd == CMD_PRE) |-> !cmd_addr[APBIT]);
    assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.cmd == CMD_NOP) || (sq_q.cmd == CMD_ACT) || (sq_q.cmd == CMD_RD)
        || (sq_q.cmd == CMD_WR) || (sq_q.cmd == CMD_PRE));
    assert_one_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({do_act, do_pre, do_rd, do_wr}) <= 1);

endmodule

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;

    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_ACT = 4'b0011;
    localparam logic [3:0] K_RD  = 4'b0101;
    localparam logic [3:0] K_WR  = 4'b0100;
    localparam logic [3:0] K_PRE = 4'b0010;

    // Spacing rules from the requirements
    localparam int T_RCD = 3, T_RP = 3, T_RAS = 6;
    localparam int G_RR = 2, G_WW = 2, G_WRD = 4, G_WPRE = 5, G_RWR = 5, G_RPRE = 2;
    localparam int NREQ_MAX = 40, NLOG_MAX = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_ready;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  cmd_ba;
    logic [12:0] cmd_addr;

    always #10 clk = ~clk;

    sdram_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_autopre(req_autopre), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .cmd_cs_n(cs_n), .cmd_ras_n(ras_n),
        .cmd_cas_n(cas_n), .cmd_we_n(we_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // request list
    int    nreq = 0;
    int    q_bank[NREQ_MAX], q_row[NREQ_MAX], q_col[NREQ_MAX], q_wr[NREQ_MAX], q_ap[NREQ_MAX];
    string q_tag[NREQ_MAX];

    task automatic add(input int b, input int r, input int c, input int w, input int a, input string t);
        q_bank[nreq] = b; q_row[nreq] = r; q_col[nreq] = c;
        q_wr[nreq] = w; q_ap[nreq] = a; q_tag[nreq] = t;
        nreq++;
    endtask

    // command log
    int cyc = 0, nlog = 0;
    int lg_kind[NLOG_MAX], lg_ba[NLOG_MAX], lg_addr[NLOG_MAX], lg_cyc[NLOG_MAX];

    always @(negedge clk) begin
        cyc++;
        if (rst_n && ({cs_n, ras_n, cas_n, we_n} != K_NOP) && nlog < NLOG_MAX) begin
            lg_kind[nlog] = int'({cs_n, ras_n, cas_n, we_n});
            lg_ba[nlog]   = int'(cmd_ba);
            lg_addr[nlog] = int'(cmd_addr);
            lg_cyc[nlog]  = cyc;
            nlog++;
        end
    end

    task automatic send(input int i);
        req_valid   = 1'b1;
        req_bank    = q_bank[i][1:0];
        req_row     = q_row[i][12:0];
        req_col     = q_col[i][9:0];
        req_write   = q_wr[i][0];
        req_autopre = q_ap[i][0];
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        check(!req_ready, $sformatf("R11 ready low after accept, req %0d", i), int'(req_ready), 0);
    endtask

    // model output
    int    nexp = 0;
    int    ex_kind[NLOG_MAX], ex_ba[NLOG_MAX], ex_addr[NLOG_MAX], ex_cyc[NLOG_MAX];
    string ex_tag[NLOG_MAX];

    task automatic emit(input int k, input int b, input int a, input int t, input string tg);
        ex_kind[nexp] = k; ex_ba[nexp] = b; ex_addr[nexp] = a;
        ex_cyc[nexp] = t; ex_tag[nexp] = tg;
        nexp++;
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_model();
        int opn[4], orow[4], t_act[4], t_pre[4], t_col[4];
        int t_rd, t_wr, tn, tc, b;
        for (int k = 0; k < 4; k++) begin
            opn[k] = 0; orow[k] = 0; t_act[k] = 0; t_pre[k] = 0; t_col[k] = 0;
        end
        t_rd = 0; t_wr = 0;
        tn = (nlog > 0) ? lg_cyc[0] : 0;
        for (int i = 0; i < nreq; i++) begin
            b = q_bank[i];
            if (opn[b] != 0 && orow[b] != q_row[i]) begin
                tc = mx(tn, t_pre[b]);
                emit(int'(K_PRE), b, 0, tc, q_tag[i]);
                t_act[b] = tc + T_RP; opn[b] = 0; tn = tc + 1;
            end
            if (opn[b] == 0) begin
                tc = mx(tn, t_act[b]);
                emit(int'(K_ACT), b, q_row[i], tc, q_tag[i]);
                t_col[b] = tc + T_RCD; t_pre[b] = tc + T_RAS;
                opn[b] = 1; orow[b] = q_row[i]; tn = tc + 1;
            end
            tc = mx(mx(tn, t_col[b]), (q_wr[i] != 0) ? t_wr : t_rd);
            emit((q_wr[i] != 0) ? int'(K_WR) : int'(K_RD), b, q_col[i] + q_ap[i] * 1024, tc, q_tag[i]);
            if (q_wr[i] != 0) begin
                t_wr = mx(t_wr, tc + G_WW); t_rd = mx(t_rd, tc + G_WRD);
                t_pre[b] = mx(t_pre[b], tc + G_WPRE);
            end else begin
                t_rd = mx(t_rd, tc + G_RR); t_wr = mx(t_wr, tc + G_RWR);
                t_pre[b] = mx(t_pre[b], tc + G_RPRE);
            end
            if (q_ap[i] != 0) begin
                t_act[b] = t_pre[b] + T_RP; opn[b] = 0;
            end
            tn = tc + 2;
        end
    endtask

    initial begin
        // directed cases (bank, row, col, write, autopre, tag)
        add(0, 5,  8, 0, 0, "R2");
        add(0, 5, 12, 0, 0, "R7");
        add(0, 5, 16, 1, 0, "R9");
        add(0, 5, 20, 1, 0, "R7");
        add(0, 5, 24, 0, 0, "R8");
        add(0, 9, 28, 0, 0, "R4");
        add(0, 9, 32, 1, 0, "R3");
        add(0, 2, 36, 1, 0, "R8");
        add(1, 1, 40, 0, 0, "R2");
        add(1, 2, 44, 0, 0, "R4");
        add(2, 7,  4, 0, 1, "R10");
        add(2, 7,  6, 0, 0, "R10");
        add(3, 3,  8, 1, 1, "R10");
        add(3, 3, 10, 1, 0, "R10");
        add(1, 2, 50, 0, 0, "R3");
        add(2, 8,  2, 1, 0, "R9");
        // sweep over banks: misses, hits, misses with one auto-precharge
        for (int k = 0; k < 12; k++)
            add(k % 4, (k < 8) ? 8000 : 8191, 1023 - k * 3, k % 2, (k == 11) ? 1 : 0, "R6");

        repeat (3) @(negedge clk);
        check({cs_n, ras_n, cas_n, we_n} == K_NOP, "R1 NOP during reset",
              int'({cs_n, ras_n, cas_n, we_n}), int'(K_NOP));
        rst_n = 1'b1;
        @(negedge clk);
        check({cs_n, ras_n, cas_n, we_n} == K_NOP, "R1 NOP after reset",
              int'({cs_n, ras_n, cas_n, we_n}), int'(K_NOP));
        check(req_ready, "R1 ready after reset", int'(req_ready), 1);

        for (int i = 0; i < nreq; i++) send(i);
        req_valid = 1'b0;
        repeat (40) @(negedge clk);

        run_model();
        check(nlog == nexp, "R3 command count", nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++) begin
            check(lg_kind[i] == ex_kind[i],
                  $sformatf("R5/%s cmd %0d code", ex_tag[i], i), lg_kind[i], ex_kind[i]);
            check(lg_ba[i] == ex_ba[i],
                  $sformatf("%s cmd %0d bank", ex_tag[i], i), lg_ba[i], ex_ba[i]);
            check(lg_addr[i] == ex_addr[i],
                  $sformatf("R6/%s cmd %0d addr", ex_tag[i], i), lg_addr[i], ex_addr[i]);
            check(lg_cyc[i] == ex_cyc[i],
                  $sformatf("%s cmd %0d cycle", ex_tag[i], i), lg_cyc[i], ex_cyc[i]);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule